// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block transmits frames described by a ring of 16-byte descriptors held in system memory. Software first programs the ring base. It then fills one or more descriptors and hands each one to hardware by setting its ownership bit. Finally it writes the poll code to kick the engine.

The engine works through the ring one descriptor at a time:
- It reads the status word. If hardware does not own the descriptor, the engine stops.
- If hardware owns it, the engine reads the buffer pointer and streams the buffer out one byte per handshake. Short frames are padded with zero bytes up to the minimum frame size.
- It writes the status word back with ownership cleared, pulses a completion flag and moves to the next descriptor.

A descriptor whose end-of-ring bit is set sends the walk back to the ring base.

Memory is reached through a word-wide read port (request held until valid) and a word-wide write port (request held until ready). Frame bytes leave on a byte-wide valid/ready stream with a last flag.

Top module: `tx_ring_poller`

## Requirements
- R1: After reset, tx_tvalid, tx_tlast, mem_rd_req, mem_wr_req and tx_ok are all low, and the current descriptor address is 0.
- R2: A config write with cfg_sel=1 and cfg_wdata[7:0]=0x40 starts a descriptor fetch at the current descriptor address. A cfg_sel=1 write with any other low byte has no effect and causes no memory read.
- R3: Descriptor layout, as byte offsets from the descriptor address:
  - The status word sits at offset 0 and the buffer pointer at offset 8. Offsets 4 and 12 are never read.
  - In the status word, bit 31 is ownership (1 = hardware), bit 30 is end of ring, and bits 12:0 are the frame length in bytes.
- R4: A fetched status word with bit 31 clear ends the walk. The engine sends nothing, writes nothing and stays idle until the next poll write.
- R5: An owned descriptor streams length bytes in ascending address order from the buffer pointer, which may have any byte alignment. Byte address A is taken from bits 8*(A mod 4)+7 : 8*(A mod 4) of the word at A rounded down to a multiple of 4. tx_tlast is high on the final byte only.
- R6: When the length is below 60, the frame is extended with zero bytes so that exactly 60 bytes are sent, with tx_tlast on the 60th. A length of 0 gives 60 zero bytes.
- R7: While tx_tvalid is high and tx_tready is low, tx_tvalid, tx_tdata and tx_tlast hold their values.
- R8: After the last byte, the engine writes the fetched status word back to offset 0 of the same descriptor, with bit 31 cleared and all other bits unchanged.
- R9: tx_ok is high for exactly one cycle, the cycle after the status write is accepted.
- R10: After a writeback, the engine fetches the next descriptor at the current address plus 16 without a new poll write.
- R11: After a descriptor whose status bit 30 is set, the next fetch is at the ring base.
- R12: A config write with cfg_sel=0 loads the ring base from cfg_wdata with bits 3:0 forced to zero. When the engine is idle, the same write also sets the current descriptor address to that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 1 | 0 selects ring base, 1 selects poll register |
| cfg_wdata | input | AW | Config write data |
| mem_rd_req | output | 1 | Read request, held until mem_rd_valid |
| mem_rd_addr | output | AW | Word-aligned read address |
| mem_rd_valid | input | 1 | Read data valid; completes the request |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Write request, held until mem_wr_ready |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Write accepted |
| tx_tdata | output | 8 | Frame byte |
| tx_tvalid | output | 1 | Byte valid |
| tx_tlast | output | 1 | Final byte of frame |
| tx_tready | input | 1 | Sink accepts byte |
| tx_ok | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions assume the memory ports behave as a well-formed slave:
- mem_rd_valid and mem_wr_ready are only ever high while the matching request is high.
- Software does not rewrite the ring base while a writeback is in flight.
- Every owned descriptor carries a length no larger than its buffer.

The bench meets these assumptions by building both memory responses combinationally from the request gated by a stall pattern. It programs the base only while the engine is idle. It sweeps every buffer alignment across lengths below, at and above the padding threshold, while the read, write and stream-ready gates each stall on their own periodic pattern.

// File: rtl/tx_ring_poller.sv
module tx_ring_poller #(
  parameter int AW = 32,
  parameter int LEN_W = 13,
  parameter int MIN_FRAME = 60,
  parameter int DESC_BYTES = 16,
  parameter logic [7:0] POLL_CODE = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  input  logic          mem_wr_ready,
  output logic [7:0]    tx_tdata,
  output logic          tx_tvalid,
  output logic          tx_tlast,
  input  logic          tx_tready,
  output logic          tx_ok
);
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;
  localparam int ALIGN_W = $clog2(DESC_BYTES);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);
  localparam logic [AW-1:0] PTR_OFS = AW'(8);

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_BUF, S_FETCH, S_SEND, S_WB} st_t;

  st_t             state;
  logic [AW-1:0]   base_q, desc_q, ptr_q;
  logic [31:0]     stat_q, word_q;
  logic [LEN_W-1:0] cnt_q;
  logic            tx_ok_q;

  wire poll = cfg_we && cfg_sel && (cfg_wdata[7:0] == POLL_CODE);
  wire [AW-1:0] base_in = {cfg_wdata[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  wire [LEN_W-1:0] len_f = stat_q[LEN_W-1:0];
  wire [LEN_W-1:0] total = (len_f < MIN_LEN) ? MIN_LEN : len_f;
  wire [LEN_W-1:0] cnt_nx = cnt_q + 1'b1;
  wire is_last = (cnt_q == total - 1'b1);
  wire in_data = (cnt_q < len_f);
  wire need_word = (cnt_nx < len_f) && (ptr_q[1:0] == 2'b11);

  assign mem_rd_req = (state == S_STAT) || (state == S_BUF) || (state == S_FETCH);
  always_comb begin
    case (state)
      S_BUF:   mem_rd_addr = desc_q + PTR_OFS;
      S_FETCH: mem_rd_addr = {ptr_q[AW-1:2], 2'b00};
      default: mem_rd_addr = desc_q;
    endcase
  end

  assign mem_wr_req  = (state == S_WB);
  assign mem_wr_addr = desc_q;
  assign mem_wr_data = {1'b0, stat_q[30:0]};

  assign tx_tvalid = (state == S_SEND);
  assign tx_tlast  = tx_tvalid && is_last;
  assign tx_tdata  = in_data ? word_q[{ptr_q[1:0], 3'b000} +: 8] : 8'h00;
  assign tx_ok     = tx_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      base_q  <= '0;
      desc_q  <= '0;
      ptr_q   <= '0;
      stat_q  <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      tx_ok_q <= 1'b0;
    end else begin
      tx_ok_q <= 1'b0;
      if (cfg_we && !cfg_sel) begin
        base_q <= base_in;
        if (state == S_IDLE) desc_q <= base_in;
      end
      case (state)
        S_IDLE: if (poll) state <= S_STAT;
        S_STAT: if (mem_rd_valid) begin
          stat_q <= mem_rd_data;
          state  <= mem_rd_data[OWN_BIT] ? S_BUF : S_IDLE;
        end
        S_BUF: if (mem_rd_valid) begin
          ptr_q <= mem_rd_data[AW-1:0];
          cnt_q <= '0;
          state <= (len_f == '0) ? S_SEND : S_FETCH;
        end
        S_FETCH: if (mem_rd_valid) begin
          word_q <= mem_rd_data;
          state  <= S_SEND;
        end
        S_SEND: if (tx_tready) begin
          cnt_q <= cnt_nx;
          ptr_q <= ptr_q + 1'b1;
          if (is_last)        state <= S_WB;
          else if (need_word) state <= S_FETCH;
        end
        S_WB: if (mem_wr_ready) begin
          tx_ok_q <= 1'b1;
          desc_q  <= stat_q[EOR_BIT] ? base_q : desc_q + STEP;
          state   <= S_STAT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

  a_r6_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tlast |-> cnt_q >= MIN_LEN - 1'b1);

  a_r8_owned_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> stat_q[OWN_BIT] && !mem_wr_data[OWN_BIT]);

  a_r9_ok_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> $past(mem_wr_req && mem_wr_ready));

  a_r9_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> !tx_ok);

  a_r4_unowned_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAT) && mem_rd_valid && !mem_rd_data[OWN_BIT] |=> (state == S_IDLE) && !tx_tvalid);

  a_r11_next_desc: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> desc_q == ($past(stat_q[EOR_BIT]) ? $past(base_q) : $past(desc_q) + STEP));

  a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req) && !(tx_tvalid && (mem_rd_req || mem_wr_req)));
endmodule

// File: tb/tb_tx_ring_poller.sv
`timescale 1ns/1ps
module tb_tx_ring_poller;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_ready;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic [7:0] tx_tdata;
  logic tx_tvalid, tx_tlast, tx_ok;
  logic tx_tready = 1'b0;
  logic rd_gate = 1'b0, wr_gate = 1'b0;

  always #4 clk = ~clk;

  logic [31:0] mem [0:2047];
  assign mem_rd_valid = mem_rd_req && rd_gate;
  assign mem_wr_ready = mem_wr_req && wr_gate;
  assign mem_rd_data  = mem[mem_rd_addr[12:2]];

  tx_ring_poller dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .tx_tdata(tx_tdata),
    .tx_tvalid(tx_tvalid), .tx_tlast(tx_tlast), .tx_tready(tx_tready), .tx_ok(tx_ok));

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] cap_b [0:4095];
  logic       cap_l [0:4095];
  int cap_n, wr_n, ok_n, rd_n, st_reads;
  logic [31:0] wlog_a [0:63];
  logic [31:0] wlog_d [0:63];
  logic [31:0] ring_lo, ring_hi;

  logic [7:0] exp_b [0:4095];
  int exp_n, nf;
  int f_st [0:63];
  int f_en [0:63];
  int f_dl [0:63];
  logic [31:0] f_stat [0:63];
  logic [31:0] f_addr [0:63];

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_gate   = (cyc % 3) != 1;
    wr_gate   = (cyc % 4) != 0;
    tx_tready = (cyc % 5) != 2 && (cyc % 7) != 3;
    if (mem_rd_req && rd_gate) begin
      rd_n = rd_n + 1;
      if (mem_rd_addr[3:0] == 4'h0 && mem_rd_addr >= ring_lo && mem_rd_addr < ring_hi)
        st_reads = st_reads + 1;
    end
    if (tx_tvalid && tx_tready && cap_n < 4096) begin
      cap_b[cap_n] = tx_tdata;
      cap_l[cap_n] = tx_tlast;
      cap_n = cap_n + 1;
    end
    if (mem_wr_req && wr_gate) begin
      if (wr_n < 64) begin
        wlog_a[wr_n] = mem_wr_addr;
        wlog_d[wr_n] = mem_wr_data;
      end
      wr_n = wr_n + 1;
      mem[mem_wr_addr[12:2]] = mem_wr_data;
    end
    if (tx_ok) ok_n = ok_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic cfg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[12:2]];
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic clear_logs(input logic [31:0] lo, input logic [31:0] hi);
    cap_n = 0; wr_n = 0; ok_n = 0; rd_n = 0; st_reads = 0;
    exp_n = 0; nf = 0; ring_lo = lo; ring_hi = hi;
  endtask

  task automatic add_desc(input logic [31:0] da, input int len, input logic [31:0] bp, input bit eor);
    logic [31:0] st;
    int tot;
    st = 32'h3000_0000 | 32'h8000_0000 | (eor ? 32'h4000_0000 : 32'h0) | 32'(len);
    mem[da[12:2]] = st;
    mem[da[12:2] + 1] = 32'hDEAD_0000 | 32'(nf);
    mem[da[12:2] + 2] = bp;
    mem[da[12:2] + 3] = 32'h0;
    tot = (len < 60) ? 60 : len;
    f_st[nf] = exp_n; f_en[nf] = exp_n + tot - 1; f_dl[nf] = len;
    f_stat[nf] = st & 32'h7FFF_FFFF; f_addr[nf] = da;
    for (int k = 0; k < tot; k++) begin
      exp_b[exp_n] = (k < len) ? mbyte(bp + 32'(k)) : 8'h00;
      exp_n++;
    end
    nf++;
  endtask

  task automatic wait_ok(input int n);
    for (int t = 0; t < 40000 && ok_n < n; t++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic verify_frames();
    chk(cap_n == exp_n, "R5 total byte count", 32'(cap_n), 32'(exp_n));
    chk(wr_n == nf, "R8 writeback count", 32'(wr_n), 32'(nf));
    chk(ok_n == nf, "R9 tx_ok pulse count", 32'(ok_n), 32'(nf));
    for (int f = 0; f < nf; f++) begin
      int bad_d, bad_p, bad_l;
      logic [31:0] fa, fe;
      bad_d = 0; bad_p = 0; bad_l = 0; fa = 0; fe = 0;
      for (int i = f_st[f]; i <= f_en[f] && i < cap_n; i++) begin
        if (cap_b[i] !== exp_b[i]) begin
          if (i - f_st[f] < f_dl[f]) begin
            if (bad_d == 0) begin fa = {24'h0, cap_b[i]}; fe = {24'h0, exp_b[i]}; end
            bad_d++;
          end else bad_p++;
        end
        if (cap_l[i] !== (i == f_en[f])) bad_l++;
      end
      chk(bad_d == 0, "R5 frame data", fa, fe);
      chk(bad_p == 0, "R6 zero padding", 32'(bad_p), 32'h0);
      chk(bad_l == 0, "R5 tlast position", 32'(bad_l), 32'h0);
      if (f < wr_n && f < 64) begin
        chk(wlog_a[f] == f_addr[f], "R10 writeback address", wlog_a[f], f_addr[f]);
        chk(wlog_d[f] == f_stat[f], "R8 writeback value", wlog_d[f], f_stat[f]);
      end
    end
  endtask

  function automatic int len_pick(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 4;   5: return 5;   6: return 59;  7: return 60;
      8: return 61;  9: return 63;  10: return 64; default: return 67;
    endcase
  endfunction

  initial begin
    repeat (20000 * 9) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    clear_logs(32'h100, 32'h400);
    repeat (3) @(negedge clk);
    chk(!tx_tvalid && !tx_tlast, "R1 stream idle in reset", {31'h0, tx_tvalid}, 32'h0);
    chk(!mem_rd_req && !mem_wr_req, "R1 memory idle in reset", {30'h0, mem_rd_req, mem_wr_req}, 32'h0);
    chk(!tx_ok, "R1 tx_ok low in reset", {31'h0, tx_ok}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Phase 1: all alignments x lengths around the pad threshold (R3, R5, R6, R10, R11)
    for (int i = 0; i < 48; i++)
      add_desc(32'h100 + 32'(i * 16), len_pick(i / 4), 32'h800 + 32'(i * 128) + 32'(i % 4), i == 47);
    cfg(1'b0, 32'h100);
    cfg(1'b1, 32'h41);
    repeat (20) @(negedge clk);
    chk(rd_n == 0, "R2 wrong poll code ignored", 32'(rd_n), 32'h0);
    cfg(1'b1, 32'h40);
    wait_ok(48);
    verify_frames();
    chk(st_reads == 49, "R11 wrap back to base then stop", 32'(st_reads), 32'd49);
    chk(!tx_tvalid && !mem_rd_req && !mem_wr_req, "R4 idle after unowned base", {31'h0, tx_tvalid}, 32'h0);

    // Phase 2: new base with unaligned low bits (R12), two-entry ring
    clear_logs(32'h500, 32'h520);
    add_desc(32'h500, 61, 32'h401, 1'b0);
    add_desc(32'h510, 0, 32'h441, 1'b1);
    cfg(1'b0, 32'h50C);
    cfg(1'b1, 32'h40);
    wait_ok(2);
    verify_frames();
    chk(st_reads == 3, "R12 base load and R11 wrap", 32'(st_reads), 32'd3);

    // Phase 3: poll on an unowned descriptor (R4)
    clear_logs(32'h500, 32'h520);
    cfg(1'b1, 32'h40);
    repeat (40) @(negedge clk);
    chk(cap_n == 0, "R4 no bytes on unowned", 32'(cap_n), 32'h0);
    chk(wr_n == 0, "R4 no writeback on unowned", 32'(wr_n), 32'h0);
    chk(st_reads == 1 && rd_n == 1, "R4 single status read", 32'(rd_n), 32'h1);
    chk(ok_n == 0, "R9 no tx_ok on unowned", 32'(ok_n), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule